// File: doc/BRIEF.md
# Acquisition Trigger and Record Controller

This block decides when a data record starts and how long it runs. A trigger can come from a software strobe, from a chosen edge on one of several external digital lines, or from auto mode, which fires by itself. Once a trigger is accepted the block waits a programmable number of clock cycles, then counts a programmable number of valid downsampled samples. After the last one it goes back to idle and reports the end of the record. Triggers that arrive while a record is running, including its delay phase, are dropped.

In auto mode the block starts the next record in the same cycle the previous one ends. The delay setting then acts as dead time between records. With zero delay the record flag stays high across the boundary, so samples stream without a gap at the pace of the upstream downsampler. Downstream logic keeps the samples for which `rec_active` and `sample_valid` are both high, and uses `trig_pulse` and `rec_done` to mark the record boundaries.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rec_active`, `trig_pulse` and `rec_done` are 0.
- R2: `cfg_mode` selects how triggers are taken: 0 = software strobe only, 1 = external edge (the software strobe is also accepted), 2 = auto (always armed), 3 = off. In modes 0 to 2, a high `sw_trig` seen at a clock edge while idle makes `trig_pulse` 1 for the following cycle.
- R3: In mode 1, the line `dig_in[cfg_ext_sel]` triggers when it goes 0 to 1 (`cfg_ext_falling` = 0) or 1 to 0 (`cfg_ext_falling` = 1). The change is seen at the first clock edge after it and produces `trig_pulse` in the next cycle. Edges on other lines, edges in the opposite direction, and any edge in mode 0 cause no trigger.
- R4: In mode 3, neither `sw_trig` nor any external edge causes a trigger.
- R5: `rec_active` rises exactly `cfg_delay` cycles after the cycle in which `trig_pulse` is high. When `cfg_delay` is 0 it rises in that same cycle.
- R6: A record takes exactly `cfg_len_m1` + 1 cycles in which `rec_active` and `sample_valid` are both high. `sample_valid` during the delay phase is not counted. `rec_done` is high for the single cycle after the last counted sample, and outside auto mode `rec_active` is 0 in that cycle.
- R7: While a record is in its delay or collect phase, no trigger source produces `trig_pulse` and the record's length is unchanged.
- R8: In auto mode with `cfg_delay` = 0, `rec_done` and `trig_pulse` are high in the same cycle and `rec_active` stays 1 across the record boundary.
- R9: In auto mode with `cfg_delay` = D > 0, `trig_pulse` coincides with `rec_done`, and `rec_active` rises again D cycles later. Leaving auto mode before a record ends stops the restart.
- R10: `cfg_len_m1` = 65535 gives a record of 65536 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | Trigger mode: 0 software, 1 external, 2 auto, 3 off |
| cfg_ext_sel | input | 2 | Index of the external line used as trigger |
| cfg_ext_falling | input | 1 | 0 = rising edge, 1 = falling edge |
| cfg_delay | input | 16 | Cycles waited between trigger and collection |
| cfg_len_m1 | input | 16 | Record length minus one, in samples |
| sw_trig | input | 1 | Software trigger strobe |
| dig_in | input | 4 | Synchronized external digital lines |
| sample_valid | input | 1 | One downsampled sample is available this cycle |
| rec_active | output | 1 | Record is collecting samples |
| trig_pulse | output | 1 | One-cycle pulse when a trigger is accepted |
| rec_done | output | 1 | One-cycle pulse after the last sample of a record |

## Verification
All outputs come from registers. `trig_pulse` appears one edge after the accepting condition: the strobe, the line change, or auto mode being selected while idle. `rec_active` follows `trig_pulse` by exactly `cfg_delay` cycles, and `rec_done` appears one edge after the last counted sample. The bench drives inputs on the falling clock edge and reads outputs on the next falling edge. The output value seen there is therefore the result of the single rising edge in between. The bench counts the delay cycles and the accepted samples itself, and compares the counts with the configured values. It also checks, at each observation point of a running record, that no extra trigger pulse appears.

// File: rtl/acq_trig_pkg.sv
`timescale 1ns/1ps
// Shared types for the acquisition trigger controller.
package acq_trig_pkg;

    // Controller phases; order is not decoded anywhere else.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DELAY   = 2'd1,
        ST_COLLECT = 2'd2
    } acq_state_e;

    // Trigger mode encoding seen on cfg_mode.
    typedef enum logic [1:0] {
        MODE_SOFT = 2'd0,
        MODE_EXT  = 2'd1,
        MODE_AUTO = 2'd2,
        MODE_OFF  = 2'd3
    } acq_mode_e;

endpackage

// File: rtl/acq_edge_pick.sv
`timescale 1ns/1ps
// Edge finder for the external trigger lines.
// Keeps last cycle's value of every line, so a change of the selector itself
// never looks like an edge. Assumes the lines are already synchronized.
// No reset: the history register reloads from the lines every cycle.
module acq_edge_pick #(
    parameter int LINES = 4,
    localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic [LINES-1:0] lines,
    input  logic [SEL_W-1:0] sel,
    input  logic             falling,
    output logic             hit
);
    logic [LINES-1:0] hist_q;
    logic [LINES-1:0] rise_v;
    logic [LINES-1:0] fall_v;

    // Purpose: remember each line's value from the previous cycle.
    always_ff @(posedge clk) begin
        hist_q <= lines;
    end

    // Per-line edge flags, one pair per line.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign rise_v[i] = lines[i] & ~hist_q[i];
        assign fall_v[i] = ~lines[i] & hist_q[i];
    end

    // Purpose: pick the wanted direction on the selected line.
    always_comb begin
        hit = falling ? fall_v[sel] : rise_v[sel];
    end

endmodule

// File: rtl/acq_down_cnt.sv
`timescale 1ns/1ps
// Loadable down counter that stops at zero.
// Load has priority over decrement. Used for both the delay phase and the
// sample count of a record.
module acq_down_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);
    logic [W-1:0] cnt_q;

    // Purpose: load, or step down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_zero = (cnt_q == '0);

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && is_zero) |=> is_zero);

endmodule

// File: rtl/acq_trigger_ctrl.sv
`timescale 1ns/1ps
// Acquisition trigger and record controller.
// Accepts a trigger while idle (software, external edge or auto), waits
// cfg_delay cycles, then counts cfg_len_m1+1 valid samples and returns to idle.
// In auto mode the next record starts in the cycle the previous one ends.
// Assumes all inputs are synchronous to clk; configuration is held steady
// during a record.
module acq_trigger_ctrl
    import acq_trig_pkg::*;
#(
    parameter int LINES   = 4,
    parameter int DELAY_W = 16,
    parameter int LEN_W   = 16,
    localparam int SEL_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic [SEL_W-1:0]   cfg_ext_sel,
    input  logic               cfg_ext_falling,
    input  logic [DELAY_W-1:0] cfg_delay,
    input  logic [LEN_W-1:0]   cfg_len_m1,
    input  logic               sw_trig,
    input  logic [LINES-1:0]   dig_in,
    input  logic               sample_valid,
    output logic               rec_active,
    output logic               trig_pulse,
    output logic               rec_done
);
    acq_mode_e  mode;
    acq_state_e state_q;
    acq_state_e state_d;
    acq_state_e entry_st;
    logic       ext_hit;
    logic       dly_zero;
    logic       smp_zero;
    logic       dly_cfg_zero;
    logic       trig_req;
    logic       last_smp;
    logic       start;
    logic       smp_load;

    assign mode         = acq_mode_e'(cfg_mode);
    assign dly_cfg_zero = (cfg_delay == '0);

    acq_edge_pick #(.LINES(LINES)) u_edge (
        .clk     (clk),
        .lines   (dig_in),
        .sel     (cfg_ext_sel),
        .falling (cfg_ext_falling),
        .hit     (ext_hit)
    );

    // Purpose: decide whether a trigger is requested and when a record ends.
    always_comb begin
        trig_req = ((mode != MODE_OFF) && sw_trig)
                 || ((mode == MODE_EXT) && ext_hit)
                 || (mode == MODE_AUTO);
        last_smp = (state_q == ST_COLLECT) && sample_valid && smp_zero;
        start    = ((state_q == ST_IDLE) && trig_req)
                 || (last_smp && (mode == MODE_AUTO));
        entry_st = dly_cfg_zero ? ST_COLLECT : ST_DELAY;
        smp_load = (start && dly_cfg_zero) || ((state_q == ST_DELAY) && dly_zero);
    end

    acq_down_cnt #(.W(DELAY_W)) u_dly_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (cfg_delay - 1'b1),
        .dec      (state_q == ST_DELAY),
        .is_zero  (dly_zero)
    );

    acq_down_cnt #(.W(LEN_W)) u_smp_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (smp_load),
        .load_val (cfg_len_m1),
        .dec      ((state_q == ST_COLLECT) && sample_valid),
        .is_zero  (smp_zero)
    );

    // Purpose: next phase of the record.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)    state_d = entry_st;
            ST_DELAY:   if (dly_zero) state_d = ST_COLLECT;
            ST_COLLECT: if (last_smp) state_d = start ? entry_st : ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Purpose: phase register and the two event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            trig_pulse <= 1'b0;
            rec_done   <= 1'b0;
        end else begin
            state_q    <= state_d;
            trig_pulse <= start;
            rec_done   <= last_smp;
        end
    end

    assign rec_active = (state_q == ST_COLLECT);

    // R7
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY) |=> !trig_pulse);

    // R6
    return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_done && !trig_pulse) |-> !rec_active);

    // R6
    done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> $past(rec_active));

    // R5
    active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_active) |-> (trig_pulse || $past(state_q == ST_DELAY)));

    // R8
    auto_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_done && $past((mode == MODE_AUTO) && dly_cfg_zero)) |-> (rec_active && trig_pulse));

endmodule

// File: tb/tb_acq_trigger_ctrl.sv
`timescale 1ns/1ps
// Directed bench: inputs change on the falling edge, outputs are read on the
// next falling edge, one rising edge later.
module tb_acq_trigger_ctrl;

    localparam int LIMIT = 80000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd3;
    logic [1:0]  cfg_ext_sel = 2'd0;
    logic        cfg_ext_falling = 1'b0;
    logic [15:0] cfg_delay = 16'd0;
    logic [15:0] cfg_len_m1 = 16'd0;
    logic        sw_trig = 1'b0;
    logic [3:0]  dig_in = 4'd0;
    logic        sample_valid = 1'b0;
    logic        rec_active;
    logic        trig_pulse;
    logic        rec_done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    acq_trigger_ctrl dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_mode        (cfg_mode),
        .cfg_ext_sel     (cfg_ext_sel),
        .cfg_ext_falling (cfg_ext_falling),
        .cfg_delay       (cfg_delay),
        .cfg_len_m1      (cfg_len_m1),
        .sw_trig         (sw_trig),
        .dig_in          (dig_in),
        .sample_valid    (sample_valid),
        .rec_active      (rec_active),
        .trig_pulse      (trig_pulse),
        .rec_done        (rec_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_outputs(input string req);
        check(rec_active === 1'b0, req, "rec_active", int'(rec_active), 0);
        check(trig_pulse === 1'b0, req, "trig_pulse", int'(trig_pulse), 0);
        check(rec_done === 1'b0, req, "rec_done", int'(rec_done), 0);
    endtask

    // Called at the falling edge where trig_pulse should be high; follows one
    // record up to the falling edge where rec_done is seen.
    task automatic follow(input int exp_dly, input int exp_n, input int sv_mod,
                          input bit hold_sw, input bit exp_restart,
                          input bit exp_active, input string req);
        int waited = 0;
        int counted = 0;
        int cyc = 0;
        int bad_trig = 0;
        bit last_sv = 1'b0;
        bit fin = 1'b0;
        check(trig_pulse === 1'b1, req, "trigger accepted", int'(trig_pulse), 1);
        while (!rec_active && waited < LIMIT) begin
            sw_trig = hold_sw;
            sample_valid = 1'b1;          // must not count during the delay (R6)
            step();
            waited++;
            if (trig_pulse !== 1'b0) bad_trig++;
        end
        check(waited == exp_dly, "R5", "delay cycles", waited, exp_dly);
        while (!fin && cyc < LIMIT + 70000) begin
            last_sv = (cyc % sv_mod) == 0;
            sw_trig = hold_sw;
            sample_valid = last_sv;
            if (last_sv && rec_active) counted++;
            step();
            cyc++;
            fin = (rec_done === 1'b1);
            if (!fin && trig_pulse !== 1'b0) bad_trig++;
        end
        sw_trig = 1'b0;
        sample_valid = 1'b0;
        check(counted == exp_n, req, "samples in record", counted, exp_n);
        check(last_sv, "R6", "done right after last sample", int'(last_sv), 1);
        check(bad_trig == 0, "R7", "extra triggers during record", bad_trig, 0);
        check(trig_pulse === exp_restart, req, "trig_pulse at done", int'(trig_pulse), int'(exp_restart));
        check(rec_active === exp_active, req, "rec_active at done", int'(rec_active), int'(exp_active));
    endtask

    task automatic t_reset();
        sw_trig = 1'b1;
        repeat (3) step();
        idle_outputs("R1");
        sw_trig = 1'b0;
        rst_n = 1'b1;
        step();
        idle_outputs("R1");
    endtask

    task automatic t_off();
        cfg_mode = 2'd3;
        sw_trig = 1'b1;
        dig_in = 4'b0001;
        step();
        idle_outputs("R4");
        dig_in = 4'b0000;
        step();
        idle_outputs("R4");
        sw_trig = 1'b0;
        step();
    endtask

    task automatic t_soft();
        cfg_mode = 2'd0;
        cfg_delay = 16'd0;
        cfg_len_m1 = 16'd2;
        sw_trig = 1'b1;
        step();
        sw_trig = 1'b0;
        follow(0, 3, 1, 1'b0, 1'b0, 1'b0, "R2");
        step();
        check(rec_done === 1'b0, "R6", "rec_done one cycle", int'(rec_done), 0);
        cfg_delay = 16'd5;
        cfg_len_m1 = 16'd3;
        sw_trig = 1'b1;
        step();
        sw_trig = 1'b0;
        follow(5, 4, 2, 1'b0, 1'b0, 1'b0, "R6");
        step();
    endtask

    task automatic t_ext();
        cfg_mode = 2'd0;
        cfg_ext_sel = 2'd2;
        cfg_ext_falling = 1'b0;
        dig_in = 4'b0100;
        step();
        check(trig_pulse === 1'b0, "R3", "edge ignored in mode 0", int'(trig_pulse), 0);
        dig_in = 4'b0000;
        step();
        cfg_mode = 2'd1;
        cfg_delay = 16'd2;
        cfg_len_m1 = 16'd0;
        dig_in = 4'b0010;
        step();
        check(trig_pulse === 1'b0, "R3", "unselected line", int'(trig_pulse), 0);
        dig_in = 4'b0110;
        step();
        follow(2, 1, 1, 1'b0, 1'b0, 1'b0, "R3");
        step();
        cfg_ext_falling = 1'b1;
        cfg_delay = 16'd0;
        cfg_len_m1 = 16'd1;
        step();
        check(trig_pulse === 1'b0, "R3", "direction change alone", int'(trig_pulse), 0);
        dig_in = 4'b0100;
        step();
        check(trig_pulse === 1'b0, "R3", "falling on unselected line", int'(trig_pulse), 0);
        dig_in = 4'b0000;
        step();
        follow(0, 2, 3, 1'b0, 1'b0, 1'b0, "R3");
        step();
        dig_in = 4'b0100;
        step();
        check(trig_pulse === 1'b0, "R3", "rising in falling mode", int'(trig_pulse), 0);
        cfg_mode = 2'd0;
        dig_in = 4'b0000;
        step();
    endtask

    task automatic t_lock();
        cfg_mode = 2'd0;
        cfg_delay = 16'd4;
        cfg_len_m1 = 16'd5;
        sw_trig = 1'b1;
        step();
        follow(4, 6, 1, 1'b1, 1'b0, 1'b0, "R7");
        step();
        check(trig_pulse === 1'b0, "R7", "no late trigger", int'(trig_pulse), 0);
    endtask

    task automatic t_auto_dead();
        cfg_delay = 16'd3;
        cfg_len_m1 = 16'd1;
        cfg_mode = 2'd2;
        step();
        follow(3, 2, 1, 1'b0, 1'b1, 1'b0, "R9");
        follow(3, 2, 1, 1'b0, 1'b1, 1'b0, "R9");
        cfg_mode = 2'd3;
        follow(3, 2, 1, 1'b0, 1'b0, 1'b0, "R9");
        step();
        idle_outputs("R9");
    endtask

    task automatic t_auto_gapless();
        cfg_delay = 16'd0;
        cfg_len_m1 = 16'd2;
        cfg_mode = 2'd2;
        step();
        follow(0, 3, 1, 1'b0, 1'b1, 1'b1, "R8");
        follow(0, 3, 1, 1'b0, 1'b1, 1'b1, "R8");
        cfg_mode = 2'd3;
        follow(0, 3, 1, 1'b0, 1'b0, 1'b0, "R8");
        step();
        idle_outputs("R8");
    endtask

    task automatic t_max_len();
        cfg_mode = 2'd0;
        cfg_delay = 16'd0;
        cfg_len_m1 = 16'hFFFF;
        sw_trig = 1'b1;
        step();
        sw_trig = 1'b0;
        follow(0, 65536, 1, 1'b0, 1'b0, 1'b0, "R10");
        step();
    endtask

    initial begin
        step();
        t_reset();
        t_off();
        t_soft();
        t_ext();
        t_lock();
        t_auto_dead();
        t_auto_gapless();
        t_max_len();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule